// File: doc/BRIEF.md
# Priority interrupt level arbiter

This block sits beside a processor core and decides, every clock, whether the core should see a hard interrupt request and which trap code goes with it. It merges sixteen external level-interrupt lines with a software-interrupt register and folds two timer-match flags into level 14. It compares the merged word against the core's current priority threshold. It honours the global interrupt enable, and it stands aside completely while a vector interrupt is pending. When the core is already inside a level-interrupt trap of higher code, a new lower-priority request is withheld.

The decision logic is a two-state machine. ARB_IDLE means no request is outstanding and the code is zero. ARB_ASSERT means a request is outstanding with a nonzero code. The transitions are named for the action taken. RAISE goes from ARB_IDLE to ARB_ASSERT when a candidate appears. RETARGET stays in ARB_ASSERT and loads a different code. DROP goes from ARB_ASSERT to ARB_IDLE when nothing pending lies above the threshold. MASK goes from ARB_ASSERT to ARB_IDLE when interrupts are disabled. HOLD keeps the state and code, and it covers vector-busy cycles, nested suppression and an unchanged candidate. The request and the code are registers, so every decision shows one clock after the inputs that caused it.

Top module: `pil_arbiter`

## Requirements
- R1: A synchronous active-high reset drives `irq_req` to 0 and `irq_code` to 0.
- R2: The pending word is `ext_pend | soft_int`, with soft bit 0 (timer match) and soft bit 15 (system-timer match) removed first. A set soft bit 15 therefore never makes level 15 pending.
- R3: When soft bit 0 or soft bit 15 is set, level 14 of the pending word is set.
- R4: While `vec_busy` is 1, `irq_req` and `irq_code` do not change, whatever the other inputs do.
- R5: When `vec_busy` is 0 and the pending word is numerically less than `2 << cur_pil`, the next cycle has `irq_req` = 0 and `irq_code` = 0. A level equal to `cur_pil` therefore never requests.
- R6: When `vec_busy` is 0, `int_en` is 1 and R5 does not apply, the candidate is 0x040 | L. L is the highest pending level above `cur_pil`. If the candidate is not suppressed and differs from `irq_code`, the next cycle shows `irq_req` = 1 and `irq_code` = candidate.
- R7: A candidate is suppressed, and the outputs hold, when `trap_lvl` > 0, `svc_code[8:4]` = 5'h04 and `svc_code` > candidate. An equal code, a code of another class, or `trap_lvl` = 0 does not suppress.
- R8: With a request outstanding, a different unsuppressed candidate replaces the code while `irq_req` stays 1. An equal candidate leaves both outputs unchanged.
- R9: When `vec_busy` is 0, `int_en` is 0 and R5 does not apply, an outstanding request is dropped with the code cleared, and no request is raised.
- R10: Outputs change only on the clock edge after the input change. They do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pend | input | 16 | External level-interrupt pending lines, bit n = level n |
| soft_int | input | 16 | Software-interrupt register; bit 0 timer match, bit 15 system-timer match |
| cur_pil | input | 4 | Current processor priority level |
| int_en | input | 1 | Global interrupt enable |
| vec_busy | input | 1 | A vector interrupt is pending; level arbitration is frozen |
| trap_lvl | input | 3 | Current trap nesting level |
| svc_code | input | 9 | Trap code currently being serviced |
| irq_req | output | 1 | Hard interrupt request to the core |
| irq_code | output | 9 | Selected trap code, zero when no request |

## Verification
The bench aims at a pending level equal to the threshold. A design using `<=` instead of strict ordering would raise a request there. The system-timer flag sits in bit 15 with the threshold at 14. A design that forgot to mask the flag would raise code 0x04F instead of dropping. Nested suppression is probed with a serviced code above, equal to, and of another class than the candidate, and with trap level zero. A wrong comparison or class test shows up as a missing or spurious request. Vector-busy cycles change every other input, so a design that keeps arbitrating moves the code. Disabling interrupts with a request outstanding shows whether the design drops the request or leaves it stuck.

// File: rtl/pil_arb_pkg.sv
package pil_arb_pkg;

    // Request state: idle means no request and a zero code.
    typedef enum logic {
        ARB_IDLE   = 1'b0,
        ARB_ASSERT = 1'b1
    } arb_state_e;

    // Action chosen on a clock edge.
    typedef enum logic [2:0] {
        ACT_HOLD     = 3'd0,
        ACT_RAISE    = 3'd1,
        ACT_RETARGET = 3'd2,
        ACT_DROP     = 3'd3,
        ACT_MASK     = 3'd4
    } arb_act_e;

endpackage

// File: rtl/pil_pend_merge.sv
module pil_pend_merge #(
    parameter int NLVL      = 16,
    parameter int TMR_BIT   = 0,
    parameter int STMR_BIT  = 15,
    parameter int TIMER_LVL = 14
) (
    input  logic [NLVL-1:0] ext_pend,
    input  logic [NLVL-1:0] soft_int,
    output logic [NLVL-1:0] pend
);
    localparam logic [NLVL-1:0] FLAG_MASK =
        (NLVL'(1) << TMR_BIT) | (NLVL'(1) << STMR_BIT);

    logic timer_hit;
    logic [NLVL-1:0] base;

    assign timer_hit = soft_int[TMR_BIT] | soft_int[STMR_BIT];
    assign base      = ext_pend | (soft_int & ~FLAG_MASK);

    // Timer flags land on their own level; other levels pass through.
    genvar g;
    generate
        for (g = 0; g < NLVL; g++) begin : g_lvl
            if (g == TIMER_LVL) begin : g_tmr
                assign pend[g] = base[g] | timer_hit;
            end else begin : g_plain
                assign pend[g] = base[g];
            end
        end
    endgenerate

endmodule

// File: rtl/pil_level_pick.sv
module pil_level_pick #(
    parameter int NLVL = 16,
    parameter int LVLW = $clog2(NLVL)
) (
    input  logic [NLVL-1:0] pend,
    input  logic [LVLW-1:0] cur_pil,
    output logic            found,
    output logic [LVLW-1:0] lvl
);
    logic [NLVL-1:0] above;
    logic [NLVL-1:0] eligible;

    // Only levels strictly above the threshold may be chosen.
    genvar g;
    generate
        for (g = 0; g < NLVL; g++) begin : g_above
            assign above[g] = (LVLW'(g) > cur_pil);
        end
    endgenerate

    assign eligible = pend & above;

    // Ascending scan, so the last hit is the highest level.
    always_comb begin
        found = 1'b0;
        lvl   = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (eligible[i]) begin
                found = 1'b1;
                lvl   = LVLW'(i);
            end
        end
    end

endmodule

// File: rtl/pil_nest_filter.sv
module pil_nest_filter #(
    parameter int                CODEW    = 9,
    parameter int                TLW      = 3,
    parameter logic [CODEW-1:0]  EXT_BASE = 9'h040
) (
    input  logic [TLW-1:0]   trap_lvl,
    input  logic [CODEW-1:0] svc_code,
    input  logic [CODEW-1:0] cand,
    output logic             block
);
    localparam int CLS_LO = 4;

    logic in_trap;
    logic svc_is_lvl;
    logic svc_higher;

    assign in_trap    = (trap_lvl != '0);
    assign svc_is_lvl = (svc_code[CODEW-1:CLS_LO] == EXT_BASE[CODEW-1:CLS_LO]);
    assign svc_higher = (svc_code > cand);
    assign block      = in_trap & svc_is_lvl & svc_higher;

endmodule

// File: rtl/pil_arbiter.sv
module pil_arbiter #(
    parameter int                NLVL      = 16,
    parameter int                LVLW      = $clog2(NLVL),
    parameter int                CODEW     = 9,
    parameter int                TLW       = 3,
    parameter int                TMR_BIT   = 0,
    parameter int                STMR_BIT  = 15,
    parameter int                TIMER_LVL = 14,
    parameter logic [CODEW-1:0]  EXT_BASE  = 9'h040
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NLVL-1:0]  ext_pend,
    input  logic [NLVL-1:0]  soft_int,
    input  logic [LVLW-1:0]  cur_pil,
    input  logic             int_en,
    input  logic             vec_busy,
    input  logic [TLW-1:0]   trap_lvl,
    input  logic [CODEW-1:0] svc_code,
    output logic             irq_req,
    output logic [CODEW-1:0] irq_code
);
    import pil_arb_pkg::*;

    localparam int THRW = NLVL + 1;

    arb_state_e       state_q, state_d;
    arb_act_e         act;
    logic [CODEW-1:0] code_q, code_d;

    logic [NLVL-1:0]  pend;
    logic             found;
    logic [LVLW-1:0]  lvl;
    logic [CODEW-1:0] cand;
    logic             block;
    logic [THRW-1:0]  thr;
    logic             below;

    pil_pend_merge #(
        .NLVL(NLVL), .TMR_BIT(TMR_BIT), .STMR_BIT(STMR_BIT), .TIMER_LVL(TIMER_LVL)
    ) merge_i (
        .ext_pend(ext_pend), .soft_int(soft_int), .pend(pend)
    );

    pil_level_pick #(.NLVL(NLVL), .LVLW(LVLW)) pick_i (
        .pend(pend), .cur_pil(cur_pil), .found(found), .lvl(lvl)
    );

    assign cand = EXT_BASE | CODEW'(lvl);

    pil_nest_filter #(.CODEW(CODEW), .TLW(TLW), .EXT_BASE(EXT_BASE)) nest_i (
        .trap_lvl(trap_lvl), .svc_code(svc_code), .cand(cand), .block(block)
    );

    assign thr   = THRW'(2) << cur_pil;
    assign below = ({1'b0, pend} < thr);

    // Next-state and action decision.
    always_comb begin
        act     = ACT_HOLD;
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (!vec_busy && !below && int_en && !block && (cand != code_q)) begin
                    act     = ACT_RAISE;
                    state_d = ARB_ASSERT;
                    code_d  = cand;
                end
            end
            ARB_ASSERT: begin
                if (!vec_busy) begin
                    if (below) begin
                        act     = ACT_DROP;
                        state_d = ARB_IDLE;
                        code_d  = '0;
                    end else if (!int_en) begin
                        act     = ACT_MASK;
                        state_d = ARB_IDLE;
                        code_d  = '0;
                    end else if (!block && (cand != code_q)) begin
                        act     = ACT_RETARGET;
                        code_d  = cand;
                    end
                end
            end
            default: begin
                state_d = ARB_IDLE;
                code_d  = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Outputs.
    always_comb begin
        irq_req  = (state_q == ARB_ASSERT);
        irq_code = code_q;
    end

    // R1
    req_code_pair_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req == (irq_code != '0));

    // R4
    vec_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        vec_busy |=> ($stable(irq_req) && $stable(irq_code)));

    // R5
    below_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!vec_busy && below) |=> (!irq_req && irq_code == '0));

    // R6
    pick_found_chk: assert property (@(posedge clk) disable iff (rst)
        !below |-> found);

    // R7
    nest_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!vec_busy && !below && int_en && block) |=> $stable(irq_code));

    // R9
    mask_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!vec_busy && !int_en) |=> !irq_req);

    // R6
    raise_class_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_code[CODEW-1:4] == EXT_BASE[CODEW-1:4]));

endmodule

// File: tb/pil_arbiter_tb.sv
`timescale 1ns/1ps
module pil_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] ext_pend;
    logic [15:0] soft_int;
    logic [3:0]  cur_pil;
    logic        int_en;
    logic        vec_busy;
    logic [2:0]  trap_lvl;
    logic [8:0]  svc_code;
    logic        irq_req;
    logic [8:0]  irq_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pil_arbiter dut_i (
        .clk(clk), .rst(rst), .ext_pend(ext_pend), .soft_int(soft_int),
        .cur_pil(cur_pil), .int_en(int_en), .vec_busy(vec_busy),
        .trap_lvl(trap_lvl), .svc_code(svc_code),
        .irq_req(irq_req), .irq_code(irq_code)
    );

    task automatic chk(input string tag, input logic er, input logic [8:0] ec);
        total++;
        if (irq_req !== er || irq_code !== ec) begin
            bad++;
            $display("FAIL %s: req=%0b code=%03h expected req=%0b code=%03h",
                     tag, irq_req, irq_code, er, ec);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next fall.
    task automatic step(input logic [15:0] e, input logic [15:0] s, input logic [3:0] p,
                        input logic en, input logic vb, input logic [2:0] tl,
                        input logic [8:0] sc);
        ext_pend = e; soft_int = s; cur_pil = p; int_en = en;
        vec_busy = vb; trap_lvl = tl; svc_code = sc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_state();
        step(16'h0, 16'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'h0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        ext_pend = 16'hFFFF; soft_int = 16'h0; cur_pil = 4'd0; int_en = 1'b1;
        vec_busy = 1'b0; trap_lvl = 3'd0; svc_code = 9'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset", 1'b0, 9'h000);
        ext_pend = 16'h0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_basic();
        clear_state();
        ext_pend = 16'h0020; cur_pil = 4'd3;
        #1;
        chk("R10 no change before edge", 1'b0, 9'h000);
        @(posedge clk); @(negedge clk);
        chk("R6 R10 level 5 raised", 1'b1, 9'h045);
        step(16'h0284, 16'h0, 4'd3, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R6 highest of 2,7,9", 1'b1, 9'h049);
        step(16'h1284, 16'h0, 4'd3, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R8 retarget to 12", 1'b1, 9'h04C);
        step(16'h1284, 16'h0, 4'd3, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R8 equal candidate holds", 1'b1, 9'h04C);
        step(16'h0284, 16'h0, 4'd3, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R8 retarget back to 9", 1'b1, 9'h049);
    endtask

    task automatic t_threshold();
        clear_state();
        step(16'h0200, 16'h0, 4'd9, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R5 level equal to pil", 1'b0, 9'h000);
        step(16'h0200, 16'h0, 4'd8, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R6 level above pil", 1'b1, 9'h049);
        step(16'h01FF, 16'h0, 4'd9, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R5 drop when only low levels", 1'b0, 9'h000);
    endtask

    task automatic t_soft();
        clear_state();
        step(16'h0, 16'h0040, 4'd2, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R2 soft level 6", 1'b1, 9'h046);
        step(16'h0, 16'h8000, 4'd2, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R3 system timer flag to 14", 1'b1, 9'h04E);
        step(16'h0, 16'h0001, 4'd2, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R3 timer flag to 14", 1'b1, 9'h04E);
        step(16'h0, 16'h8000, 4'd14, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R2 flag bit 15 not level 15", 1'b0, 9'h000);
        step(16'h8000, 16'h0, 4'd14, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R2 external level 15", 1'b1, 9'h04F);
    endtask

    task automatic t_vec();
        clear_state();
        step(16'h0020, 16'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R6 setup level 5", 1'b1, 9'h045);
        step(16'h0800, 16'h0, 4'd0, 1'b1, 1'b1, 3'd0, 9'h0);
        chk("R4 busy ignores new level", 1'b1, 9'h045);
        step(16'h0000, 16'h0, 4'd0, 1'b0, 1'b1, 3'd0, 9'h0);
        chk("R4 busy ignores disable and empty", 1'b1, 9'h045);
        step(16'h0000, 16'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R5 drop after busy clears", 1'b0, 9'h000);
        step(16'h0800, 16'h0, 4'd0, 1'b1, 1'b1, 3'd0, 9'h0);
        chk("R4 busy blocks raise", 1'b0, 9'h000);
    endtask

    task automatic t_disable();
        clear_state();
        step(16'h0020, 16'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R6 setup level 5", 1'b1, 9'h045);
        step(16'h0020, 16'h0, 4'd0, 1'b0, 1'b0, 3'd0, 9'h0);
        chk("R9 disable drops", 1'b0, 9'h000);
        step(16'h0400, 16'h0, 4'd0, 1'b0, 1'b0, 3'd0, 9'h0);
        chk("R9 no raise while disabled", 1'b0, 9'h000);
        step(16'h0400, 16'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'h0);
        chk("R6 raise on enable", 1'b1, 9'h04A);
    endtask

    task automatic t_nest();
        clear_state();
        step(16'h0020, 16'h0, 4'd0, 1'b1, 1'b0, 3'd1, 9'h04C);
        chk("R7 higher serviced suppresses", 1'b0, 9'h000);
        step(16'h0020, 16'h0, 4'd0, 1'b1, 1'b0, 3'd1, 9'h045);
        chk("R7 equal serviced raises", 1'b1, 9'h045);
        step(16'h0220, 16'h0, 4'd0, 1'b1, 1'b0, 3'd1, 9'h04C);
        chk("R7 suppressed retarget holds", 1'b1, 9'h045);
        clear_state();
        step(16'h0020, 16'h0, 4'd0, 1'b1, 1'b0, 3'd1, 9'h060);
        chk("R7 other class raises", 1'b1, 9'h045);
        clear_state();
        step(16'h0020, 16'h0, 4'd0, 1'b1, 1'b0, 3'd0, 9'h04C);
        chk("R7 trap level zero raises", 1'b1, 9'h045);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_threshold();
        t_soft();
        t_vec();
        t_disable();
        t_nest();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule